// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block turns a virtual address into a physical address for an instruction fetch, a data load or a data store. It works out the effective privilege of the access. It then reads page-table entries one level at a time through a single read port, starting at the root table and moving down. Each leaf entry it finds is checked against the access. The block reports either a translated physical address or a fault, and each fault is labelled as a page fault or an access fault.

The geometry is fixed to three levels, nine index bits per level, eight-byte entries and a physical page number that starts at entry bit 10. Pages are 4 KiB. A caller raises `reqValid` while `reqReady` is high and then waits for a one-cycle `respValid` pulse. The memory side answers each `memReqValid` pulse with a `memRspValid` pulse, which comes at least one cycle later. With that pulse it returns either an entry or an error flag that marks the entry address as not backed by memory. The walker never writes to an entry. If an accessed or dirty bit is missing, the access faults.

Top module: `pt_walker`

## Requirements
- R1: The walk is bare when `vmEnable` is 0 or the effective privilege is machine (3). In a bare walk the result is the virtual address unchanged, with no fault and no entry read. If `xlen32` is 1, bits 63:32 of the result are cleared.
- R2: Privilege is encoded U=0, S=1, M=3. Access types are encoded fetch=0, load=1, store=2. For a load or store with `mprv`=1 and `debugMode`=0, the effective privilege is `mpp`. In every other case it is `curPriv`.
- R3: In a translated walk, if address bits 63:38 are not all zeros or all ones, the result is a page fault and no entry is read.
- R4: Entries are read from level 2 down to level 0. At level i the entry address is base*4096 + vaddr[12+9i +: 9]*8. The first base is `rootPpn`. Each `memReqValid` lasts one cycle, and only one read is outstanding at a time.
- R5: A response with `memRspErr`=1 ends the walk with an access fault (`respAccessFault`=1).
- R6: An entry with V=1 (bit 0) and R, W and X (bits 1, 2, 3) all clear points to the next table, whose base is entry bits 53:10. If such a pointer is found at level 0, the result is a page fault.
- R7: A leaf with U (bit 4) set faults in S mode when the access is a fetch or `sumBit`=0. A leaf with U clear faults when the effective privilege is not S.
- R8: A leaf with V clear faults. A leaf with W set and R clear faults. A fetch needs X. A load needs R, or X when `mxrBit`=1. A store needs both R and W.
- R9: A leaf found at level i faults as a misaligned superpage if any of the low 9*i bits of its page number are set.
- R10: A leaf faults if A (bit 6) is clear. A store also faults if D (bit 7) is clear.
- R11: A successful translation returns ((page number OR the low 9*i virtual page number bits) << 12) OR vaddr[11:0].
- R12: `reqReady` is high only while the walker is idle, including right after reset. `respValid` is a one-cycle pulse. `respType` repeats the access type of the request, so a fault can be classed as an instruction, load or store fault. Every fault that is not an access fault has `respAccessFault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Start a walk |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 64 | Virtual address |
| reqType | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| curPriv | input | 2 | Current privilege |
| mprv | input | 1 | Use `mpp` as privilege for data accesses |
| mpp | input | 2 | Alternate privilege for data accesses |
| debugMode | input | 1 | Hart is in debug mode, so `mprv` is ignored |
| vmEnable | input | 1 | 1 selects three-level translation, 0 selects bare |
| xlen32 | input | 1 | Bare result is zero-extended from 32 bits |
| sumBit | input | 1 | S mode may load or store to user pages |
| mxrBit | input | 1 | Executable pages are readable |
| rootPpn | input | 44 | Page number of the root table |
| memReqValid | output | 1 | Entry read request pulse |
| memReqAddr | output | 64 | Entry address |
| memRspValid | input | 1 | Entry response pulse |
| memRspErr | input | 1 | Entry address is not legal memory |
| memRspData | input | 64 | Entry value |
| respValid | output | 1 | Result pulse |
| respFault | output | 1 | Walk faulted |
| respAccessFault | output | 1 | The fault is an access fault, not a page fault |
| respType | output | 2 | Access type of the finished walk |
| respPaddr | output | 64 | Physical address when no fault |

## Verification
The walker is driven with several kinds of address. Bare and machine-mode addresses show that no entry is read. A non-canonical address and a sign-extended high address show that the canonical check runs before any read. A three-level walk is used with a different leaf flag set each time. Each flag set fails exactly one check in the permission, privilege or A/D group, so each check can be seen on its own. A one-gigabyte superpage, once aligned and once misaligned, shows the merging of the low page-number bits and the alignment fault. A pointer that leads into illegal memory, and a pointer found at the last level, show the difference between an access fault and a page fault. The recorded entry addresses confirm the order of the levels and the index arithmetic.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_G = 5;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [1:0] {
    RES_BARE   = 2'd0,
    RES_LEAF   = 2'd1,
    RES_PAGE   = 2'd2,
    RES_ACCESS = 2'd3
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    descend;
    logic    finish;
    result_e result;
  } ctlStrobes_t;

  // verdicts from datapath to control
  typedef struct packed {
    logic bare;
    logic nonCanon;
    logic lastLevel;
    logic isTable;
    logic leafOk;
  } walkStatus_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        memRspErr,
  input  walkStatus_t status,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        respValid,
  output ctlStrobes_t ctl
);

  walkState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.result  = RES_PAGE;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.bare) begin
          ctl.finish = 1'b1;
          ctl.result = RES_BARE;
          stateNext  = ST_DONE;
        end else if (status.nonCanon) begin
          ctl.finish = 1'b1;
          ctl.result = RES_PAGE;
          stateNext  = ST_DONE;
        end else begin
          stateNext  = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            ctl.finish = 1'b1;
            ctl.result = RES_ACCESS;
            stateNext  = ST_DONE;
          end else if (status.isTable && !status.lastLevel) begin
            ctl.descend = 1'b1;
            stateNext   = ST_ISSUE;
          end else if (!status.isTable && status.leafOk) begin
            ctl.finish = 1'b1;
            ctl.result = RES_LEAF;
            stateNext  = ST_DONE;
          end else begin
            ctl.finish = 1'b1;
            ctl.result = RES_PAGE;
            stateNext  = ST_DONE;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign respValid   = (state == ST_DONE);

  // R4: a read request is a single-cycle pulse, never back to back
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R12: result is a pulse followed by idle
  a_r12_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  // R12: an accepted request makes the walker busy
  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int LEVELS     = 3,
  parameter int IDX_BITS   = 9,
  parameter int PTE_BYTES  = 8,
  parameter int PPN_LSB    = 10,
  parameter int PPN_BITS   = 44,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic                  memReqValid,
  input  logic                  respValid,
  input  logic [XLEN-1:0]       reqVaddr,
  input  logic [1:0]            reqType,
  input  logic [1:0]            curPriv,
  input  logic                  mprv,
  input  logic [1:0]            mpp,
  input  logic                  debugMode,
  input  logic                  vmEnable,
  input  logic                  xlen32,
  input  logic                  sumBit,
  input  logic                  mxrBit,
  input  logic [PPN_BITS-1:0]   rootPpn,
  input  logic [PTE_BYTES*8-1:0] memRspData,
  output walkStatus_t           status,
  output logic [XLEN-1:0]       memReqAddr,
  output logic                  respFault,
  output logic                  respAccessFault,
  output logic [1:0]            respType,
  output logic [XLEN-1:0]       respPaddr
);

  localparam int PTE_W     = PTE_BYTES * 8;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);
  localparam int VPN_W     = LEVELS * IDX_BITS;
  localparam int VA_BITS   = PAGE_SHIFT + VPN_W;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int HI_W      = XLEN - VA_BITS + 1;

  logic [XLEN-1:0]     vaddrQ;
  logic [1:0]          typeQ;
  logic [1:0]          privQ;
  logic                sumQ, mxrQ, is32Q, bareQ;
  logic [PPN_BITS-1:0] baseQ;
  logic [LVL_W-1:0]    levelQ;

  // effective privilege of the incoming request (R2)
  logic [1:0] effPriv;
  always_comb begin
    effPriv = curPriv;
    if (reqType != ACC_FETCH && mprv && !debugMode) effPriv = mpp;
  end

  // address fields
  logic [VPN_W-1:0]    vpn;
  logic [HI_W-1:0]     upperBits;
  int                  levelShift;
  logic [IDX_BITS-1:0] vpnIdx;
  logic [PPN_BITS-1:0] lowMask;

  assign vpn        = vaddrQ[VA_BITS-1:PAGE_SHIFT];
  assign upperBits  = vaddrQ[XLEN-1:VA_BITS-1];
  assign levelShift = int'(levelQ) * IDX_BITS;
  assign vpnIdx     = IDX_BITS'(vpn >> levelShift);
  assign lowMask    = (PPN_BITS'(1) << levelShift) - PPN_BITS'(1);

  assign memReqAddr = XLEN'({baseQ, {PAGE_SHIFT{1'b0}}}) + (XLEN'(vpnIdx) << PTE_SHIFT);

  // entry decode
  logic [PPN_BITS-1:0] ptePpn;
  logic pV, pR, pW, pX, pU, pA, pD;
  logic unusedPteBits;

  assign ptePpn = memRspData[PPN_LSB +: PPN_BITS];
  assign pV = memRspData[BIT_V];
  assign pR = memRspData[BIT_R];
  assign pW = memRspData[BIT_W];
  assign pX = memRspData[BIT_X];
  assign pU = memRspData[BIT_U];
  assign pA = memRspData[BIT_A];
  assign pD = memRspData[BIT_D];
  assign unusedPteBits = ^{memRspData[PTE_W-1:PPN_LSB+PPN_BITS],
                           memRspData[PPN_LSB-1:BIT_D+1], memRspData[BIT_G]};

  // leaf checks, kept in the order a walk applies them
  logic isStore, isFetch, isLoad;
  logic privFault, fmtFault, permFault, alignFault, adFault;

  assign isFetch = (typeQ == ACC_FETCH);
  assign isLoad  = (typeQ == ACC_LOAD);
  assign isStore = (typeQ == ACC_STORE);

  always_comb begin
    if (pU) privFault = (privQ == PRIV_S) && (isFetch || !sumQ);
    else    privFault = (privQ != PRIV_S);
    fmtFault = !pV || (!pR && pW);
    if (isFetch)     permFault = !pX;
    else if (isLoad) permFault = !pR && !(mxrQ && pX);
    else             permFault = !(pR && pW);
    alignFault = |(ptePpn & lowMask);
    adFault    = !pA || (isStore && !pD);
  end

  assign status.bare      = bareQ;
  assign status.nonCanon  = !((&upperBits) || !(|upperBits));
  assign status.lastLevel = (levelQ == '0);
  assign status.isTable   = pV && !pR && !pW && !pX;
  assign status.leafOk    = !privFault && !fmtFault && !permFault && !alignFault && !adFault;

  // walk state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ <= '0;
      typeQ  <= ACC_FETCH;
      privQ  <= PRIV_U;
      sumQ   <= 1'b0;
      mxrQ   <= 1'b0;
      is32Q  <= 1'b0;
      bareQ  <= 1'b0;
      baseQ  <= '0;
      levelQ <= '0;
    end else if (ctl.capture) begin
      vaddrQ <= reqVaddr;
      typeQ  <= reqType;
      privQ  <= effPriv;
      sumQ   <= sumBit;
      mxrQ   <= mxrBit;
      is32Q  <= xlen32;
      bareQ  <= !vmEnable || (effPriv == PRIV_M);
      baseQ  <= rootPpn;
      levelQ <= LVL_W'(LEVELS - 1);
    end else if (ctl.descend) begin
      baseQ  <= ptePpn;
      levelQ <= levelQ - LVL_W'(1);
    end
  end

  // result registers
  logic [PPN_BITS-1:0] mergedPpn;
  assign mergedPpn = ptePpn | (PPN_BITS'(vpn) & lowMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respFault       <= 1'b0;
      respAccessFault <= 1'b0;
      respPaddr       <= '0;
    end else if (ctl.finish) begin
      unique case (ctl.result)
        RES_BARE: begin
          respFault       <= 1'b0;
          respAccessFault <= 1'b0;
          respPaddr       <= is32Q ? (vaddrQ & XLEN'(32'hFFFF_FFFF)) : vaddrQ;
        end
        RES_LEAF: begin
          respFault       <= 1'b0;
          respAccessFault <= 1'b0;
          respPaddr       <= XLEN'({mergedPpn, vaddrQ[PAGE_SHIFT-1:0]});
        end
        RES_PAGE: begin
          respFault       <= 1'b1;
          respAccessFault <= 1'b0;
          respPaddr       <= '0;
        end
        RES_ACCESS: begin
          respFault       <= 1'b1;
          respAccessFault <= 1'b1;
          respPaddr       <= '0;
        end
        default: ;
      endcase
    end
  end

  assign respType = typeQ;

  // R4: every entry address is aligned to the entry size
  a_r4_pte_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[PTE_SHIFT-1:0] == '0));

  // R3: no entry is read for a non-canonical address
  a_r3_no_read_noncanon: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !status.nonCanon);

  // R11: a successful result keeps the page offset
  a_r11_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> (respPaddr[PAGE_SHIFT-1:0] == vaddrQ[PAGE_SHIFT-1:0]));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int LEVELS     = 3,
  parameter int IDX_BITS   = 9,
  parameter int PTE_BYTES  = 8,
  parameter int PPN_LSB    = 10,
  parameter int PPN_BITS   = 44,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [XLEN-1:0]        reqVaddr,
  input  logic [1:0]             reqType,
  input  logic [1:0]             curPriv,
  input  logic                   mprv,
  input  logic [1:0]             mpp,
  input  logic                   debugMode,
  input  logic                   vmEnable,
  input  logic                   xlen32,
  input  logic                   sumBit,
  input  logic                   mxrBit,
  input  logic [PPN_BITS-1:0]    rootPpn,
  output logic                   memReqValid,
  output logic [XLEN-1:0]        memReqAddr,
  input  logic                   memRspValid,
  input  logic                   memRspErr,
  input  logic [PTE_BYTES*8-1:0] memRspData,
  output logic                   respValid,
  output logic                   respFault,
  output logic                   respAccessFault,
  output logic [1:0]             respType,
  output logic [XLEN-1:0]        respPaddr
);

  ctlStrobes_t ctl;
  walkStatus_t status;

  ptw_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .status      (status),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .respValid   (respValid),
    .ctl         (ctl)
  );

  ptw_datapath #(
    .XLEN       (XLEN),
    .LEVELS     (LEVELS),
    .IDX_BITS   (IDX_BITS),
    .PTE_BYTES  (PTE_BYTES),
    .PPN_LSB    (PPN_LSB),
    .PPN_BITS   (PPN_BITS),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) i_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .ctl             (ctl),
    .memReqValid     (memReqValid),
    .respValid       (respValid),
    .reqVaddr        (reqVaddr),
    .reqType         (reqType),
    .curPriv         (curPriv),
    .mprv            (mprv),
    .mpp             (mpp),
    .debugMode       (debugMode),
    .vmEnable        (vmEnable),
    .xlen32          (xlen32),
    .sumBit          (sumBit),
    .mxrBit          (mxrBit),
    .rootPpn         (rootPpn),
    .memRspData      (memRspData),
    .status          (status),
    .memReqAddr      (memReqAddr),
    .respFault       (respFault),
    .respAccessFault (respAccessFault),
    .respType        (respType),
    .respPaddr       (respPaddr)
  );

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqType = 2'd0;
  logic [1:0]  curPriv = 2'd1;
  logic        mprv = 1'b0;
  logic [1:0]  mpp = 2'd0;
  logic        debugMode = 1'b0;
  logic        vmEnable = 1'b1;
  logic        xlen32 = 1'b0;
  logic        sumBit = 1'b0;
  logic        mxrBit = 1'b0;
  logic [43:0] rootPpn = 44'h100;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic        memRspErr = 1'b0;
  logic [63:0] memRspData = '0;
  logic        respValid, respFault, respAccessFault;
  logic [1:0]  respType;
  logic [63:0] respPaddr;

  always #10 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqType(reqType), .curPriv(curPriv), .mprv(mprv),
    .mpp(mpp), .debugMode(debugMode), .vmEnable(vmEnable), .xlen32(xlen32),
    .sumBit(sumBit), .mxrBit(mxrBit), .rootPpn(rootPpn),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .memRspData(memRspData),
    .respValid(respValid), .respFault(respFault),
    .respAccessFault(respAccessFault), .respType(respType), .respPaddr(respPaddr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic        fault;
    logic        access;
    logic [63:0] paddr;
    logic [1:0]  typ;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [63:0] pteMem [logic [63:0]];
  logic [63:0] memLog[$];

  localparam logic [63:0] F_V = 64'h01, F_R = 64'h02, F_W = 64'h04, F_X = 64'h08,
                          F_U = 64'h10, F_A = 64'h40, F_D = 64'h80;
  localparam logic [63:0] ERR_BASE = 64'hF000_0000;

  function automatic logic [63:0] mkPte(logic [63:0] ppn, logic [63:0] flags);
    return (ppn << 10) | flags;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle response, error above ERR_BASE
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        logic [63:0] a;
        a = memReqAddr;
        memLog.push_back(a);
        @(negedge clk);
        memRspValid = 1'b1;
        memRspErr   = (a >= ERR_BASE);
        memRspData  = pteMem.exists(a) ? pteMem[a] : 64'h0;
      end
    end
  end

  // monitor: compare results against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (respValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected response", 64'(respValid), 64'h0);
        end else begin
          exp_t e;
          bit ok;
          e  = expQ.pop_front();
          ok = (respFault == e.fault) && (respType == e.typ) &&
               (!e.fault || respAccessFault == e.access) &&
               (e.fault || respPaddr == e.paddr);
          check(ok, e.tag,
                {respFault, respAccessFault, respType, respPaddr[59:0]},
                {e.fault, e.access, e.typ, e.paddr[59:0]});
        end
      end
    end
  end

  task automatic runWalk(logic [63:0] va, logic [1:0] typ, logic fault,
                         logic access, logic [63:0] paddr, string tag);
    exp_t e;
    while (!reqReady) @(negedge clk);
    e.fault = fault; e.access = access; e.paddr = paddr; e.typ = typ; e.tag = tag;
    expQ.push_back(e);
    reqVaddr = va;
    reqType  = typ;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [63:0] VA_A = 64'h4040_3567;
  localparam logic [63:0] LEAF_A = 64'h10_2018;

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && respValid == 1'b0 && memReqValid == 1'b0,
          "R12 reset state", {61'h0, reqReady, respValid, memReqValid}, 64'h4);
    rstN = 1'b1;
    @(negedge clk);

    // page tables: root 0x100 -> 0x101 -> 0x102
    pteMem[64'h10_0008] = mkPte(64'h101, F_V);
    pteMem[64'h10_1010] = mkPte(64'h102, F_V);
    pteMem[LEAF_A]      = mkPte(64'h5555, F_V|F_R|F_W|F_A|F_D);
    pteMem[64'h10_0018] = mkPte(64'hF0000, F_V);                 // leads to illegal memory
    pteMem[64'h10_0020] = mkPte(64'h40000, F_V|F_R|F_W|F_A|F_D);  // aligned 1 GiB page
    pteMem[64'h10_0028] = mkPte(64'h40001, F_V|F_R|F_A);          // misaligned 1 GiB page
    pteMem[64'h10_2020] = mkPte(64'h200, F_V);                    // pointer at level 0

    // R1 bare
    vmEnable = 1'b0;
    runWalk(64'hFFFF_FFFF_1234_5678, 2'd0, 0, 0, 64'hFFFF_FFFF_1234_5678, "R1 bare full width");
    xlen32 = 1'b1;
    runWalk(64'hFFFF_FFFF_1234_5678, 2'd1, 0, 0, 64'h1234_5678, "R1 bare zero-extend 32");
    xlen32 = 1'b0;
    vmEnable = 1'b1;
    memLog.delete();
    curPriv = 2'd3;
    runWalk(VA_A, 2'd1, 0, 0, VA_A, "R1 machine mode passthrough");
    check(memLog.size() == 0, "R1 no read in bare walk", 64'(memLog.size()), 64'h0);
    curPriv = 2'd1;

    // R3 canonical
    memLog.delete();
    runWalk(64'h0000_0040_0000_0000, 2'd1, 1, 0, 0, "R3 non-canonical page fault");
    check(memLog.size() == 0, "R3 no read when non-canonical", 64'(memLog.size()), 64'h0);
    runWalk(64'hFFFF_FFC0_0000_1000, 2'd1, 1, 0, 0, "R3 negative canonical walked");
    check(memLog.size() == 1 && memLog[0] == 64'h10_0800, "R3 negative address read",
          memLog.size() > 0 ? memLog[0] : 64'h0, 64'h10_0800);

    // R4, R11 full walk
    memLog.delete();
    runWalk(VA_A, 2'd1, 0, 0, 64'h555_5567, "R11 three-level load");
    check(memLog.size() == 3, "R4 three reads", 64'(memLog.size()), 64'h3);
    if (memLog.size() == 3) begin
      check(memLog[0] == 64'h10_0008, "R4 level 2 address", memLog[0], 64'h10_0008);
      check(memLog[1] == 64'h10_1010, "R4 level 1 address", memLog[1], 64'h10_1010);
      check(memLog[2] == LEAF_A,      "R4 level 0 address", memLog[2], LEAF_A);
    end
    runWalk(VA_A, 2'd2, 0, 0, 64'h555_5567, "R11 three-level store");

    // R10 accessed / dirty
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_A);
    runWalk(VA_A, 2'd2, 1, 0, 0, "R10 store without D");
    runWalk(VA_A, 2'd1, 0, 0, 64'h555_5567, "R10 load without D ok");
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_D);
    runWalk(VA_A, 2'd1, 1, 0, 0, "R10 load without A");

    // R8 permission and format
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_A|F_D);
    runWalk(VA_A, 2'd0, 1, 0, 0, "R8 fetch without X");
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_X|F_A|F_D);
    runWalk(VA_A, 2'd0, 0, 0, 64'h555_5567, "R8 fetch with X");
    runWalk(VA_A, 2'd1, 1, 0, 0, "R8 load execute-only mxr=0");
    mxrBit = 1'b1;
    runWalk(VA_A, 2'd1, 0, 0, 64'h555_5567, "R8 load execute-only mxr=1");
    mxrBit = 1'b0;
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_A|F_D);
    runWalk(VA_A, 2'd2, 1, 0, 0, "R8 store read-only");
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_W|F_X|F_A|F_D);
    runWalk(VA_A, 2'd0, 1, 0, 0, "R8 write without read");
    pteMem[LEAF_A] = mkPte(64'h5555, F_R|F_W|F_X|F_A|F_D);
    runWalk(VA_A, 2'd1, 1, 0, 0, "R8 invalid leaf");

    // R7 user bit
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_X|F_U|F_A|F_D);
    runWalk(VA_A, 2'd1, 1, 0, 0, "R7 S load user page sum=0");
    sumBit = 1'b1;
    runWalk(VA_A, 2'd1, 0, 0, 64'h555_5567, "R7 S load user page sum=1");
    runWalk(VA_A, 2'd0, 1, 0, 0, "R7 S fetch user page sum=1");
    sumBit = 1'b0;
    curPriv = 2'd0;
    runWalk(VA_A, 2'd0, 0, 0, 64'h555_5567, "R7 U fetch user page");
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_X|F_A|F_D);
    runWalk(VA_A, 2'd1, 1, 0, 0, "R7 U load supervisor page");

    // R2 effective privilege
    curPriv = 2'd3; mprv = 1'b1; mpp = 2'd0;
    runWalk(VA_A, 2'd1, 1, 0, 0, "R2 mprv load uses mpp=U");
    pteMem[LEAF_A] = mkPte(64'h5555, F_V|F_R|F_W|F_X|F_U|F_A|F_D);
    runWalk(VA_A, 2'd2, 0, 0, 64'h555_5567, "R2 mprv store translated");
    runWalk(VA_A, 2'd0, 0, 0, VA_A, "R2 fetch ignores mprv");
    debugMode = 1'b1;
    runWalk(VA_A, 2'd1, 0, 0, VA_A, "R2 debug mode ignores mprv");
    debugMode = 1'b0; mprv = 1'b0; curPriv = 2'd1;

    // R5 access fault, type echoed
    runWalk(64'hC000_0000, 2'd1, 1, 1, 0, "R5 load access fault");
    runWalk(64'hC000_0000, 2'd2, 1, 1, 0, "R5 store access fault");
    runWalk(64'hC000_0000, 2'd0, 1, 1, 0, "R5 fetch access fault");

    // R6 pointer at last level
    runWalk(64'h4040_4000, 2'd1, 1, 0, 0, "R6 pointer at level 0");

    // R9, R11 superpages
    runWalk(64'h1_00A0_6ABC, 2'd1, 0, 0, 64'h40A0_6ABC, "R11 gigapage merge");
    runWalk(64'h1_4000_0123, 2'd1, 1, 0, 0, "R9 misaligned gigapage");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=%h expected=%h", 64'h0, 64'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule